// File: doc/BRIEF.md
# Dual-Issue Instruction Pairing Unit

The unit sits between decode and two integer execution pipes. Each cycle it looks at the head instruction and the one after it and decides whether both issue in this cycle, the head issues alone, or nothing issues. The head always goes to the general pipe, which accepts any instruction. The follower may go to the secondary pipe, which takes only simple hardwired operations. A read-after-write hazard, a microcoded head, a follower carrying a prefix, or floating-point work outside the exchange rule all send the head through alone.

A prefixed head pays one extra clock. The unit spends one stall cycle in which nothing is consumed and then issues the head. A floating-point stack exchange at the head rides for free with the next floating-point operation, but only when the last instruction issued was a floating-point operation that left the stack depth unchanged. A one-bit history register records that fact from one cycle to the next.

The control is a two-state machine. `ST_READY` is the normal state. A valid prefixed head in `ST_READY` raises `stall` and takes the transition to `ST_PREFIX_PAID`. In `ST_PREFIX_PAID` the head issues under the normal pairing rules, and the machine returns to `ST_READY` in every case. Synchronous reset returns the machine to `ST_READY` and clears the history bit.

Top module: `pair_issue_unit`

## Requirements
- R1: While `rst` is high, `issue_u`, `issue_v` and `stall` are 0 and `consumed` is 0. After reset the history bit is clear, so an exchange at the head cannot pair until a qualifying floating-point operation has issued.
- R2: Two valid instructions issue together (`consumed`=2) when all of these hold: the head is neither microcoded nor floating-point; the follower has `b_simple`=1, is not floating-point and has no prefix; and `a_dst & b_src` is zero.
- R3: When `a_dst & b_src` is non-zero, the follower does not issue and the head issues alone. Overlapping destination masks alone do not block pairing.
- R4: A follower with `b_simple`=0 never issues alongside an integer head.
- R5: A head with `a_micro`=1 issues alone.
- R6: With `b_valid`=0, a valid head issues alone. With `a_valid`=0, nothing issues and `consumed` is 0.
- R7: A valid head with `a_prefix`=1 first produces one cycle with `stall`=1 and `consumed`=0, then issues in the next cycle under the normal pairing rules. A follower with `b_prefix`=1 never pairs.
- R8: An exchange at the head (`a_fxch`=1, with `a_fp`=1) pairs with a valid, unprefixed floating-point follower that is not itself an exchange, provided the history bit is set.
- R9: An exchange at the head that fails any condition of R8 issues alone with `consumed`=1.
- R10: When an instruction issues, the history bit takes the value "fp=1, pop=0, not an exchange" of the last instruction issued (the follower if a pair issued, else the head). A stall cycle or an idle cycle leaves the bit unchanged.
- R11: Apart from R8, a floating-point instruction in either slot prevents pairing.
- R12: `issue_u` is 1 exactly when `consumed` is 1 or 2, and `issue_v` is 1 exactly when `consumed` is 2. `stall` is raised only with `consumed`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| a_valid | input | 1 | Head instruction present |
| a_micro | input | 1 | Head is a complex microcoded instruction |
| a_prefix | input | 1 | Head carries a prefix byte |
| a_fp | input | 1 | Head is a floating-point instruction |
| a_fpop | input | 1 | Head pops the floating-point stack |
| a_fxch | input | 1 | Head is a floating-point stack exchange |
| a_dst | input | REG_W | Head destination register mask |
| b_valid | input | 1 | Follower instruction present |
| b_simple | input | 1 | Follower is a simple hardwired operation |
| b_prefix | input | 1 | Follower carries a prefix byte |
| b_fp | input | 1 | Follower is a floating-point instruction |
| b_fpop | input | 1 | Follower pops the floating-point stack |
| b_fxch | input | 1 | Follower is a floating-point stack exchange |
| b_src | input | REG_W | Follower source register mask |
| issue_u | output | 1 | Head issues to the general pipe this cycle |
| issue_v | output | 1 | Follower issues to the secondary pipe this cycle |
| stall | output | 1 | Prefix stall cycle |
| consumed | output | 2 | Instructions taken this cycle (0, 1 or 2) |

## Verification
All four outputs are combinational from the inputs, the state and the history bit. The bench therefore drives each stimulus on a falling edge and checks the outputs one nanosecond later, in the same cycle. The effect of the history bit shows one cycle after the issue that set it. The bench checks it with an exchange-plus-floating-point probe applied in the cycle after each case. A prefixed head takes two cycles: the stall is checked in the first cycle and the issue decision in the second, with the inputs held unchanged.

// File: rtl/pair_pkg.sv
package pair_pkg;

    typedef enum logic {
        ST_READY       = 1'b0,
        ST_PREFIX_PAID = 1'b1
    } pair_state_t;

    localparam logic [1:0] TAKE_NONE = 2'd0;
    localparam logic [1:0] TAKE_ONE  = 2'd1;
    localparam logic [1:0] TAKE_TWO  = 2'd2;

    // A floating-point operation that leaves the stack depth as it was
    function automatic logic keeps_stack(input logic fp, input logic fpop, input logic fxch);
        return fp & ~fpop & ~fxch;
    endfunction

endpackage

// File: rtl/pair_rules.sv
module pair_rules #(
    parameter int REG_W = 8
) (
    input  logic             a_micro,
    input  logic             a_fp,
    input  logic             a_fxch,
    input  logic [REG_W-1:0] a_dst,
    input  logic             b_valid,
    input  logic             b_simple,
    input  logic             b_prefix,
    input  logic             b_fp,
    input  logic             b_fxch,
    input  logic [REG_W-1:0] b_src,
    input  logic             fp_hist,
    output logic             can_pair
);

    logic raw_hazard;
    logic int_ok;
    logic xchg_ok;

    always_comb begin
        raw_hazard = |(a_dst & b_src);
        int_ok     = ~a_micro & ~a_fp & ~b_fp & b_simple & ~raw_hazard;
        xchg_ok    = a_fxch & fp_hist & b_fp & ~b_fxch;
        can_pair   = b_valid & ~b_prefix & (int_ok | xchg_ok);
    end

endmodule

// File: rtl/fp_history.sv
module fp_history (
    input  logic clk,
    input  logic rst,
    input  logic upd,
    input  logic upd_val,
    output logic hist
);

    always_ff @(posedge clk) begin
        if (rst) begin
            hist <= 1'b0;
        end else if (upd) begin
            hist <= upd_val;
        end
    end

endmodule

// File: rtl/pair_fsm.sv
module pair_fsm
    import pair_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       head_valid,
    input  logic       head_prefix,
    input  logic       can_pair,
    output logic       issue_u,
    output logic       issue_v,
    output logic       stall,
    output logic [1:0] consumed
);

    pair_state_t state_q;
    pair_state_t state_d;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_READY;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        state_d  = state_q;
        stall    = 1'b0;
        consumed = TAKE_NONE;
        unique case (state_q)
            ST_READY: begin
                if (head_valid && head_prefix) begin
                    stall   = 1'b1;
                    state_d = ST_PREFIX_PAID;
                end else if (head_valid) begin
                    consumed = can_pair ? TAKE_TWO : TAKE_ONE;
                end
            end
            ST_PREFIX_PAID: begin
                if (head_valid) begin
                    consumed = can_pair ? TAKE_TWO : TAKE_ONE;
                end
                state_d = ST_READY;
            end
            default: state_d = ST_READY;
        endcase
        if (rst) begin
            stall    = 1'b0;
            consumed = TAKE_NONE;
        end
        issue_u = (consumed != TAKE_NONE);
        issue_v = (consumed == TAKE_TWO);
    end

endmodule

// File: rtl/pair_issue_unit.sv
module pair_issue_unit
    import pair_pkg::*;
#(
    parameter int REG_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             a_valid,
    input  logic             a_micro,
    input  logic             a_prefix,
    input  logic             a_fp,
    input  logic             a_fpop,
    input  logic             a_fxch,
    input  logic [REG_W-1:0] a_dst,
    input  logic             b_valid,
    input  logic             b_simple,
    input  logic             b_prefix,
    input  logic             b_fp,
    input  logic             b_fpop,
    input  logic             b_fxch,
    input  logic [REG_W-1:0] b_src,
    output logic             issue_u,
    output logic             issue_v,
    output logic             stall,
    output logic [1:0]       consumed
);

    logic fp_hist;
    logic can_pair;
    logic hist_val;

    pair_rules #(.REG_W(REG_W)) u_rules (
        .a_micro  (a_micro),
        .a_fp     (a_fp),
        .a_fxch   (a_fxch),
        .a_dst    (a_dst),
        .b_valid  (b_valid),
        .b_simple (b_simple),
        .b_prefix (b_prefix),
        .b_fp     (b_fp),
        .b_fxch   (b_fxch),
        .b_src    (b_src),
        .fp_hist  (fp_hist),
        .can_pair (can_pair)
    );

    pair_fsm u_fsm (
        .clk         (clk),
        .rst         (rst),
        .head_valid  (a_valid),
        .head_prefix (a_prefix),
        .can_pair    (can_pair),
        .issue_u     (issue_u),
        .issue_v     (issue_v),
        .stall       (stall),
        .consumed    (consumed)
    );

    // Record describes the last instruction that left this cycle
    assign hist_val = issue_v ? keeps_stack(b_fp, b_fpop, b_fxch)
                              : keeps_stack(a_fp, a_fpop, a_fxch);

    fp_history u_hist (
        .clk     (clk),
        .rst     (rst),
        .upd     (issue_u),
        .upd_val (hist_val),
        .hist    (fp_hist)
    );

endmodule

// File: rtl/pair_issue_unit_chk.sv
module pair_issue_unit_chk #(
    parameter int REG_W = 8
) (
    input logic             clk,
    input logic             rst,
    input logic             a_valid,
    input logic             a_micro,
    input logic             a_prefix,
    input logic             a_fp,
    input logic             a_fpop,
    input logic             a_fxch,
    input logic [REG_W-1:0] a_dst,
    input logic             b_valid,
    input logic             b_simple,
    input logic             b_prefix,
    input logic             b_fp,
    input logic             b_fpop,
    input logic             b_fxch,
    input logic [REG_W-1:0] b_src,
    input logic             issue_u,
    input logic             issue_v,
    input logic             stall,
    input logic [1:0]       consumed
);

    always @(posedge clk) begin
        if (rst) begin
            AST_QUIET_IN_RESET: assert (!issue_u && !issue_v && !stall && consumed == 2'd0); // R1
        end
    end

    AST_V_NEEDS_U: assert property (@(posedge clk) disable iff (rst)
        issue_v |-> issue_u); // R12

    AST_STALL_TAKES_NONE: assert property (@(posedge clk) disable iff (rst)
        stall |-> (consumed == 2'd0)); // R12

    AST_NO_PAIR_ON_RAW: assert property (@(posedge clk) disable iff (rst)
        issue_v |-> ((a_dst & b_src) == '0 || a_fxch)); // R3

    AST_V_ONLY_SIMPLE: assert property (@(posedge clk) disable iff (rst)
        (issue_v && !a_fxch) |-> b_simple); // R4

    AST_MICRO_ALONE: assert property (@(posedge clk) disable iff (rst)
        (a_valid && a_micro) |-> !issue_v); // R5

    AST_EMPTY_HEAD_IDLE: assert property (@(posedge clk) disable iff (rst)
        !a_valid |-> (consumed == 2'd0)); // R6

    AST_ONE_STALL_ONLY: assert property (@(posedge clk) disable iff (rst)
        stall |=> !stall); // R7

    AST_PREFIXED_FOLLOWER: assert property (@(posedge clk) disable iff (rst)
        b_prefix |-> !issue_v); // R7

endmodule

bind pair_issue_unit pair_issue_unit_chk #(.REG_W(REG_W)) chk (.*);

// File: tb/pair_issue_unit_test.sv
module pair_issue_unit_test;

    localparam int K_INT   = 0;
    localparam int K_CPLX  = 1;
    localparam int K_MICRO = 2;
    localparam int K_FPNP  = 3;
    localparam int K_FPPOP = 4;
    localparam int K_XCHG  = 5;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic a_valid = 0, a_micro = 0, a_prefix = 0, a_fp = 0, a_fpop = 0, a_fxch = 0;
    logic b_valid = 0, b_simple = 0, b_prefix = 0, b_fp = 0, b_fpop = 0, b_fxch = 0;
    logic [7:0] a_dst = '0, b_src = '0;
    logic issue_u, issue_v, stall;
    logic [1:0] consumed;

    int checks = 0;
    int fails  = 0;

    always #2 clk = ~clk;

    pair_issue_unit uut (.*);

    task automatic check(input string req, input logic [1:0] exp_c, input logic exp_s);
        logic eu, ev;
        eu = (exp_c != 0);
        ev = (exp_c == 2);
        checks++;
        if (consumed !== exp_c || stall !== exp_s || issue_u !== eu || issue_v !== ev) begin
            fails++;
            $display("FAIL %s: consumed=%0d stall=%0b u=%0b v=%0b expected consumed=%0d stall=%0b u=%0b v=%0b",
                     req, consumed, stall, issue_u, issue_v, exp_c, exp_s, eu, ev);
        end
    endtask

    task automatic set_a(input int k, input logic v, input logic p, input logic [7:0] d);
        a_valid = v; a_prefix = p; a_dst = d;
        a_micro = (k == K_MICRO);
        a_fp    = (k >= K_FPNP);
        a_fpop  = (k == K_FPPOP);
        a_fxch  = (k == K_XCHG);
    endtask

    task automatic set_b(input int k, input logic v, input logic p, input logic [7:0] s);
        b_valid = v; b_prefix = p; b_src = s;
        b_simple = (k == K_INT);
        b_fp     = (k >= K_FPNP);
        b_fpop   = (k == K_FPPOP);
        b_fxch   = (k == K_XCHG);
    endtask

    // Requirement-level model of one issue decision for a valid head
    task automatic decide(input int ka, input int kb, input logic bv, input logic bp,
                          input logic dep, input logic hist,
                          output logic [1:0] c, output string tag);
        if (!bv)                         begin c = 1; tag = "R6";  end
        else if (ka == K_MICRO)          begin c = 1; tag = "R5";  end
        else if (bp)                     begin c = 1; tag = "R7";  end
        else if (ka == K_XCHG) begin
            if (hist && (kb == K_FPNP || kb == K_FPPOP)) begin c = 2; tag = "R8"; end
            else                                         begin c = 1; tag = "R9"; end
        end
        else if (ka >= K_FPNP || kb >= K_FPNP) begin c = 1; tag = "R11"; end
        else if (kb != K_INT)            begin c = 1; tag = "R4";  end
        else if (dep)                    begin c = 1; tag = "R3";  end
        else                             begin c = 2; tag = "R2";  end
    endtask

    initial begin
        #800000;
        fails++;
        checks++;
        $display("FAIL watchdog: run did not complete, expected completion");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        // R1: outputs quiet while reset is held, even with a valid pair present
        @(negedge clk);
        rst = 1'b1;
        set_a(K_INT, 1, 0, 8'h01);
        set_b(K_INT, 1, 0, 8'h02);
        #1 check("R1 reset", 2'd0, 1'b0);
        @(negedge clk);
        set_a(K_INT, 1, 1, 8'h01);
        #1 check("R1 reset prefix", 2'd0, 1'b0);
        @(negedge clk);
        rst = 1'b0;
        // R1: history is clear after reset, so an exchange issues alone
        set_a(K_XCHG, 1, 0, 8'h00);
        set_b(K_FPNP, 1, 0, 8'h00);
        #1 check("R1 history clear", 2'd1, 1'b0);

        for (int prime = 0; prime < 3; prime++)
        for (int ka = 0; ka < 6; ka++)
        for (int kb = 0; kb < 6; kb++)
        for (int vv = 0; vv < 4; vv++)
        for (int pp = 0; pp < 4; pp++)
        for (int dep = 0; dep < 2; dep++) begin
            logic av, bv, ap, bp, hist, hist_next;
            logic [1:0] c;
            string tag;
            av = vv[1]; bv = vv[0]; ap = pp[1]; bp = pp[0];
            @(negedge clk);
            rst = 1'b1;
            set_a(K_INT, 0, 0, 8'h00);
            set_b(K_INT, 0, 0, 8'h00);
            @(negedge clk);
            rst = 1'b0;
            hist = 1'b0;
            if (prime != 0) begin
                set_a(prime == 1 ? K_FPNP : K_FPPOP, 1, 0, 8'h00);
                set_b(K_INT, 0, 0, 8'h00);
                #1 check("R6 single head", 2'd1, 1'b0);
                hist = (prime == 1);
                @(negedge clk);
            end
            // a_dst overlaps b_src only when dep is set
            set_a(ka, av, ap, 8'h05);
            set_b(kb, bv, bp, dep ? 8'h04 : 8'h0A);
            if (!av) begin
                #1 check("R6 empty head", 2'd0, 1'b0);
                hist_next = hist;
            end else begin
                decide(ka, kb, bv, bp, dep[0], hist, c, tag);
                if (ap) begin
                    #1 check("R7 prefix stall", 2'd0, 1'b1);
                    @(negedge clk);
                end
                #1 check(ap ? {tag, " after R7 stall"} : tag, c, 1'b0);
                hist_next = (c == 2) ? (kb == K_FPNP) : (ka == K_FPNP);
            end
            // R10 probe: exchange plus fp follower pairs only if history set
            @(negedge clk);
            set_a(K_XCHG, 1, 0, 8'h00);
            set_b(K_FPPOP, 1, 0, 8'h00);
            #1 check("R10 history", hist_next ? 2'd2 : 2'd1, 1'b0);
        end

        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule